// File: doc/BRIEF.md
# Infrared Pulse-Width Frame Receiver

This block turns a demodulated infrared remote-control line into data frames. The line is looked at only on a slow sampling enable, produced internally by dividing the system clock by `TICK_DIV`. While waiting, the receiver looks for a start pattern: a low pulse followed by a high pulse, each with a width inside its own programmable window. Once that pattern is accepted, the block measures the time between successive falling edges. Each such period becomes one data bit, and the bits are collected least significant first into a store of up to `MAX_BITS` bits.

A frame closes in one of two ways. The first is when the time since the last falling edge reaches a programmed cycle limit. The second is when the line has been held low for longer than a programmed limit. When a frame closes, the data word, the bit count, the end cause and the overflow flag all change in the same cycle, and `frame_done` pulses. The receiver then waits for the next start pattern.

`frame_done` acts as a valid strobe with no ready. There is no back-pressure: the result stays on the outputs until the next frame closes and replaces it. The line input is assumed to be already synchronous to `clk`. All thresholds are plain input ports, counted in sampling ticks.

Top module: `ir_pulse_rx`

## Requirements
- R1: The line is sampled only on the sampling enable, which fires on every `TICK_DIV`-th clock. The first enable comes on the `TICK_DIV`-th rising edge after reset is released. Every output changes only in the clock cycle that follows an enable.
- R2: After reset, all outputs are 0. A frame result can only follow an accepted start pattern. Pulses on the line that do not form a start pattern leave every output unchanged.
- R3: A start pattern is accepted when two conditions hold. The low width, measured from a falling edge to the next rising edge, must lie in [`cfg_ldr_lo_min`, `cfg_ldr_lo_max`]. The high width that follows, up to the next falling edge, must lie in [`cfg_ldr_hi_min`, `cfg_ldr_hi_max`]. On acceptance, `irq_leader` pulses for exactly one cycle. A pattern outside either window raises no pulse.
- R4: After a start pattern, each falling edge produces one bit, judged on the period in ticks since the previous falling edge. The bit is 1 when that period is at least `cfg_bit_thr`, and 0 otherwise. The first bit lands in `rx_data[0]`, and bits not received read 0.
- R5: At most `MAX_BITS` (72) bits are kept. Later bits are dropped, `bit_count` stays at 72, and `overflow` reads 1 for that frame.
- R6: If no falling edge arrives and the tick count since the last falling edge reaches `cfg_max_cycle`, the frame ends. In that case `irq_maxcyc` pulses together with `frame_done`, and `end_low` is 0.
- R7: If the line stays low for more than `cfg_low_limit` ticks, counted from the last falling edge, the frame ends with `end_low` = 1 and no `irq_maxcyc`. When this and the R6 condition arise on the same tick, this end wins.
- R8: `rx_data`, `bit_count`, `end_low` and `overflow` change only in the cycle where `frame_done` pulses, and they hold until the next frame end.
- R9: After a frame ends, the receiver needs a new start pattern before it accepts any further bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated line, idle high |
| cfg_ldr_lo_min | input | CNT_W | Minimum start-pattern low width in ticks |
| cfg_ldr_lo_max | input | CNT_W | Maximum start-pattern low width in ticks |
| cfg_ldr_hi_min | input | CNT_W | Minimum start-pattern high width in ticks |
| cfg_ldr_hi_max | input | CNT_W | Maximum start-pattern high width in ticks |
| cfg_bit_thr | input | CNT_W | Period at or above which a bit is 1 |
| cfg_max_cycle | input | CNT_W | Ticks without a falling edge that end a frame |
| cfg_low_limit | input | CNT_W | Low width that, when exceeded, ends a frame |
| irq_leader | output | 1 | One-cycle pulse when a start pattern is accepted |
| irq_maxcyc | output | 1 | One-cycle pulse when the cycle limit ends a frame |
| frame_done | output | 1 | One-cycle valid strobe for a new frame result |
| rx_data | output | MAX_BITS | Received bits, first bit at index 0 |
| bit_count | output | $clog2(MAX_BITS+1) | Number of bits kept |
| end_low | output | 1 | 1 when the low-width limit ended the frame |
| overflow | output | 1 | 1 when more than MAX_BITS bits arrived |

## Verification
The two end conditions can fire on the same sampling tick. The bench provokes this by setting `cfg_low_limit` to one less than `cfg_max_cycle` and then leaving the line low after a data falling edge, so both counters cross their limits together. The result is judged by requiring `end_low` = 1 with no `irq_maxcyc` pulse. A behavioural model, compared on every clock, also checks the cycle in which `frame_done` appears.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_LDR_LO = 2'd1,
    ST_LDR_HI = 2'd2,
    ST_DATA   = 2'd3
  } rx_state_e;

  function automatic logic [31:0] sat_inc32(input logic [31:0] v, input int unsigned w);
    logic [31:0] lim;
    lim = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/ir_line_sampler.sv
module ir_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ir_in,
  output logic fall,
  output logic rise,
  output logic line_low
);
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line_q <= 1'b1;
    else if (tick) line_q <= ir_in;
  end

  assign fall     = tick &  line_q & ~ir_in;
  assign rise     = tick & ~line_q &  ir_in;
  assign line_low = ~ir_in;
endmodule

// File: rtl/ir_frame_ctrl.sv
module ir_frame_ctrl
  import ir_rx_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fall,
  input  logic             rise,
  input  logic             line_low,
  input  logic [CNT_W-1:0] cfg_ldr_lo_min,
  input  logic [CNT_W-1:0] cfg_ldr_lo_max,
  input  logic [CNT_W-1:0] cfg_ldr_hi_min,
  input  logic [CNT_W-1:0] cfg_ldr_hi_max,
  input  logic [CNT_W-1:0] cfg_bit_thr,
  input  logic [CNT_W-1:0] cfg_max_cycle,
  input  logic [CNT_W-1:0] cfg_low_limit,
  output logic             start_frame,
  output logic             take_bit,
  output logic             bit_val,
  output logic             fin_max,
  output logic             fin_low,
  output logic             irq_leader,
  output logic             irq_maxcyc
);
  rx_state_e        state_q;
  logic [CNT_W-1:0] per_q, low_q;
  logic [CNT_W-1:0] per_nx, low_nx;
  logic             lo_ok, hi_ok, in_data;

  assign per_nx  = CNT_W'(sat_inc32(32'(per_q), CNT_W));
  assign low_nx  = line_low ? CNT_W'(sat_inc32(32'(low_q), CNT_W)) : '0;
  assign lo_ok   = (per_q >= cfg_ldr_lo_min) && (per_q <= cfg_ldr_lo_max);
  assign hi_ok   = (per_q >= cfg_ldr_hi_min) && (per_q <= cfg_ldr_hi_max);
  assign in_data = (state_q == ST_DATA);

  assign start_frame = fall && (state_q == ST_LDR_HI) && hi_ok;
  assign take_bit    = fall && in_data;
  assign bit_val     = (per_q >= cfg_bit_thr);
  assign fin_low     = tick && in_data && !fall && (low_nx > cfg_low_limit);
  assign fin_max     = tick && in_data && !fall && !fin_low && (per_nx >= cfg_max_cycle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      per_q   <= '0;
      low_q   <= '0;
    end else if (tick) begin
      unique case (state_q)
        ST_WAIT: begin
          if (fall) begin
            state_q <= ST_LDR_LO;
            per_q   <= CNT_W'(1);
          end
        end
        ST_LDR_LO: begin
          if (rise) begin
            state_q <= lo_ok ? ST_LDR_HI : ST_WAIT;
            per_q   <= CNT_W'(1);
          end else if (per_nx > cfg_ldr_lo_max) begin
            state_q <= ST_WAIT;
          end else begin
            per_q <= per_nx;
          end
        end
        ST_LDR_HI: begin
          if (fall) begin
            state_q <= hi_ok ? ST_DATA : ST_LDR_LO;
            per_q   <= CNT_W'(1);
            low_q   <= CNT_W'(1);
          end else if (per_nx > cfg_ldr_hi_max) begin
            state_q <= ST_WAIT;
          end else begin
            per_q <= per_nx;
          end
        end
        ST_DATA: begin
          if (fall) begin
            per_q <= CNT_W'(1);
            low_q <= CNT_W'(1);
          end else if (fin_low || fin_max) begin
            state_q <= ST_WAIT;
          end else begin
            per_q <= per_nx;
            low_q <= low_nx;
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_leader <= 1'b0;
      irq_maxcyc <= 1'b0;
    end else begin
      irq_leader <= start_frame;
      irq_maxcyc <= fin_max;
    end
  end
endmodule

// File: rtl/ir_bit_store.sv
module ir_bit_store #(
  parameter int MAX_BITS = 72,
  localparam int BC_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_frame,
  input  logic                take_bit,
  input  logic                bit_val,
  input  logic                fin_max,
  input  logic                fin_low,
  output logic                frame_done,
  output logic [MAX_BITS-1:0] rx_data,
  output logic [BC_W-1:0]     bit_count,
  output logic                end_low,
  output logic                overflow
);
  localparam logic [BC_W-1:0] FULL = BC_W'(MAX_BITS);

  logic [MAX_BITS-1:0] acc_q;
  logic [BC_W-1:0]     cnt_q;
  logic                ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (start_frame) begin
      acc_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (take_bit) begin
      if (cnt_q < FULL) begin
        acc_q[cnt_q] <= bit_val;
        cnt_q        <= cnt_q + 1'b1;
      end else begin
        ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      rx_data    <= '0;
      bit_count  <= '0;
      end_low    <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      frame_done <= fin_max | fin_low;
      if (fin_max | fin_low) begin
        rx_data   <= acc_q;
        bit_count <= cnt_q;
        end_low   <= fin_low;
        overflow  <= ovf_q;
      end
    end
  end
endmodule

// File: rtl/ir_pulse_rx.sv
module ir_pulse_rx #(
  parameter int TICK_DIV = 4,
  parameter int CNT_W    = 12,
  parameter int MAX_BITS = 72,
  localparam int BC_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ir_in,
  input  logic [CNT_W-1:0]    cfg_ldr_lo_min,
  input  logic [CNT_W-1:0]    cfg_ldr_lo_max,
  input  logic [CNT_W-1:0]    cfg_ldr_hi_min,
  input  logic [CNT_W-1:0]    cfg_ldr_hi_max,
  input  logic [CNT_W-1:0]    cfg_bit_thr,
  input  logic [CNT_W-1:0]    cfg_max_cycle,
  input  logic [CNT_W-1:0]    cfg_low_limit,
  output logic                irq_leader,
  output logic                irq_maxcyc,
  output logic                frame_done,
  output logic [MAX_BITS-1:0] rx_data,
  output logic [BC_W-1:0]     bit_count,
  output logic                end_low,
  output logic                overflow
);
  logic tick_w, fall_w, rise_w, low_w;
  logic start_w, take_w, bitv_w, fmax_w, flow_w;

  ir_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  ir_line_sampler u_line (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .ir_in(ir_in),
    .fall(fall_w), .rise(rise_w), .line_low(low_w)
  );

  ir_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick_w),
    .fall(fall_w), .rise(rise_w), .line_low(low_w),
    .cfg_ldr_lo_min(cfg_ldr_lo_min), .cfg_ldr_lo_max(cfg_ldr_lo_max),
    .cfg_ldr_hi_min(cfg_ldr_hi_min), .cfg_ldr_hi_max(cfg_ldr_hi_max),
    .cfg_bit_thr(cfg_bit_thr), .cfg_max_cycle(cfg_max_cycle),
    .cfg_low_limit(cfg_low_limit),
    .start_frame(start_w), .take_bit(take_w), .bit_val(bitv_w),
    .fin_max(fmax_w), .fin_low(flow_w),
    .irq_leader(irq_leader), .irq_maxcyc(irq_maxcyc)
  );

  ir_bit_store #(.MAX_BITS(MAX_BITS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .start_frame(start_w), .take_bit(take_w), .bit_val(bitv_w),
    .fin_max(fmax_w), .fin_low(flow_w),
    .frame_done(frame_done), .rx_data(rx_data), .bit_count(bit_count),
    .end_low(end_low), .overflow(overflow)
  );
endmodule

// File: rtl/ir_rx_checker.sv
module ir_rx_checker #(
  parameter int MAX_BITS = 72,
  localparam int BC_W = $clog2(MAX_BITS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                irq_leader,
  input logic                irq_maxcyc,
  input logic                frame_done,
  input logic [MAX_BITS-1:0] rx_data,
  input logic [BC_W-1:0]     bit_count,
  input logic                end_low,
  input logic                overflow
);
  assert_pulse_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_leader || irq_maxcyc || frame_done) |-> $past(tick));

  assert_leader_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_leader |=> !irq_leader);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bit_count) <= MAX_BITS);

  assert_ovf_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (32'(bit_count) == MAX_BITS));

  assert_maxcyc_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_maxcyc |-> (frame_done && !end_low));

  assert_low_no_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && end_low) |-> !irq_maxcyc);

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> ($stable(rx_data) && $stable(bit_count) && $stable(end_low) && $stable(overflow)));

  assert_leader_not_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_leader && frame_done));
endmodule

bind ir_pulse_rx ir_rx_checker #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w),
  .irq_leader(irq_leader), .irq_maxcyc(irq_maxcyc), .frame_done(frame_done),
  .rx_data(rx_data), .bit_count(bit_count), .end_low(end_low), .overflow(overflow)
);

// File: tb/ir_pulse_rx_test.sv
`timescale 1ns/1ps
module ir_pulse_rx_test;
  localparam int DIV = 4;
  localparam int CW  = 12;
  localparam int MB  = 72;
  localparam int BW  = $clog2(MB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_in = 1'b1;
  logic [CW-1:0] lo_min = 14, lo_max = 18, hi_min = 6, hi_max = 10;
  logic [CW-1:0] bthr = 6, maxc = 20, lowlim = 12;
  logic irq_leader, irq_maxcyc, frame_done, end_low, overflow;
  logic [MB-1:0] rx_data;
  logic [BW-1:0] bit_count;

  always #2.5 clk = ~clk;

  ir_pulse_rx #(.TICK_DIV(DIV), .CNT_W(CW), .MAX_BITS(MB)) uut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in),
    .cfg_ldr_lo_min(lo_min), .cfg_ldr_lo_max(lo_max),
    .cfg_ldr_hi_min(hi_min), .cfg_ldr_hi_max(hi_max),
    .cfg_bit_thr(bthr), .cfg_max_cycle(maxc), .cfg_low_limit(lowlim),
    .irq_leader(irq_leader), .irq_maxcyc(irq_maxcyc), .frame_done(frame_done),
    .rx_data(rx_data), .bit_count(bit_count), .end_low(end_low), .overflow(overflow)
  );

  int checks = 0, fails = 0, cycles = 0;
  int n_ldr = 0, n_max = 0, n_done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, evaluated at every rising edge
  int  m_div = 0, m_st = 0, m_per = 0, m_low = 0;
  bit  m_line = 1, m_ovf = 0;
  bit  m_bits[$];
  bit  m_ldr = 0, m_max = 0, m_done = 0, m_endlow = 0, m_ovfo = 0;
  logic [MB-1:0] m_data = '0;
  int  m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_st = 0; m_per = 0; m_low = 0; m_line = 1; m_ovf = 0;
      m_bits.delete(); m_ldr = 0; m_max = 0; m_done = 0;
      m_endlow = 0; m_ovfo = 0; m_data = '0; m_cnt = 0;
    end else begin
      bit tk, s, fl, rs;
      int nper, nlow;
      m_ldr = 0; m_max = 0; m_done = 0;
      tk = (m_div == DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      if (tk) begin
        s = ir_in; fl = m_line && !s; rs = !m_line && s;
        nper = m_per + 1;
        nlow = s ? 0 : m_low + 1;
        case (m_st)
          0: if (fl) begin m_st = 1; m_per = 1; end
          1: if (rs) begin
               m_st = (m_per >= lo_min && m_per <= lo_max) ? 2 : 0; m_per = 1;
             end else if (nper > lo_max) m_st = 0;
             else m_per = nper;
          2: if (fl) begin
               if (m_per >= hi_min && m_per <= hi_max) begin
                 m_st = 3; m_ldr = 1; m_bits.delete(); m_ovf = 0; m_low = 1;
               end else m_st = 1;
               m_per = 1;
             end else if (nper > hi_max) m_st = 0;
             else m_per = nper;
          default: if (fl) begin
               if (m_bits.size() < MB) m_bits.push_back(m_per >= bthr);
               else m_ovf = 1;
               m_per = 1; m_low = 1;
             end else if (nlow > lowlim || nper >= maxc) begin
               m_done = 1; m_endlow = (nlow > lowlim); m_max = !m_endlow;
               m_ovfo = m_ovf; m_cnt = m_bits.size(); m_data = '0;
               foreach (m_bits[i]) m_data[i] = m_bits[i];
               m_st = 0;
             end else begin m_per = nper; m_low = nlow; end
        endcase
        m_line = s;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (irq_leader) n_ldr++;
      if (irq_maxcyc) n_max++;
      if (frame_done) n_done++;
      chk(irq_leader === m_ldr, "R3 model irq_leader", irq_leader, m_ldr);
      chk(irq_maxcyc === m_max, "R6 model irq_maxcyc", irq_maxcyc, m_max);
      chk(frame_done === m_done, "R1 model frame_done timing", frame_done, m_done);
      chk(rx_data === m_data, "R8 model rx_data", rx_data[63:0], m_data[63:0]);
      chk(bit_count === BW'(m_cnt), "R8 model bit_count", bit_count, m_cnt);
      chk(end_low === m_endlow, "R7 model end_low", end_low, m_endlow);
      chk(overflow === m_ovfo, "R5 model overflow", overflow, m_ovfo);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic hold(input bit lvl, input int ticks);
    ir_in = lvl;
    repeat (ticks * DIV) @(negedge clk);
  endtask
  task automatic leader(); hold(0, 16); hold(1, 8); endtask
  task automatic send_bit(input bit b); hold(0, 2); hold(1, b ? 6 : 2); endtask

  logic [MB-1:0] exp;
  int c0;

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_leader === 0 && frame_done === 0 && rx_data === '0 && bit_count === 0,
        "R2 reset state", {irq_leader, frame_done}, 0);
    rst_n = 1'b1;
    hold(1, 5);

    // frame A: 8 bits, ended by cycle limit (R4, R6)
    exp = '0;
    leader();
    for (int i = 0; i < 8; i++) begin
      bit b = ((8'hB5 >> i) & 1) != 0;
      exp[i] = b; send_bit(b);
    end
    hold(0, 2); hold(1, 30);
    chk(n_ldr == 1, "R3 leader irq count", n_ldr, 1);
    chk(rx_data === exp, "R4 data LSB first", rx_data[7:0], exp[7:0]);
    chk(bit_count == 8, "R4 bit count", bit_count, 8);
    chk(n_max == 1 && end_low == 0, "R6 max-cycle end", n_max, 1);

    // frame B: 80 bits, overflow (R5)
    exp = '0;
    leader();
    for (int i = 0; i < 80; i++) begin
      bit b = (i % 3) == 0;
      if (i < MB) exp[i] = b;
      send_bit(b);
    end
    hold(0, 2); hold(1, 30);
    chk(bit_count == MB, "R5 count saturates", bit_count, MB);
    chk(overflow == 1, "R5 overflow flag", overflow, 1);
    chk(rx_data === exp, "R5 first 72 bits kept", rx_data[63:0], exp[63:0]);

    // frame C: excess low end (R7)
    exp = '0;
    leader();
    for (int i = 0; i < 5; i++) begin exp[i] = i[0]; send_bit(i[0]); end
    c0 = n_max;
    hold(0, 30); hold(1, 10);
    chk(end_low == 1, "R7 excess low end", end_low, 1);
    chk(n_max == c0, "R7 no max irq", n_max, c0);
    chk(bit_count == 5 && rx_data === exp, "R7 data kept", bit_count, 5);

    // frame D: both ends on one tick, low wins (R7)
    lowlim = 19;
    leader();
    send_bit(1); send_bit(1);
    c0 = n_max;
    hold(0, 30); hold(1, 10);
    chk(end_low == 1 && n_max == c0, "R7 coincident ends", end_low, 1);
    chk(bit_count == 2, "R7 coincident count", bit_count, 2);
    lowlim = 12;

    // bad leader, then data-like pulses: ignored (R2, R9)
    c0 = n_done;
    hold(0, 8); hold(1, 8);
    for (int i = 0; i < 6; i++) send_bit(1);
    hold(1, 30);
    chk(n_done == c0, "R9 no frame without leader", n_done, c0);
    chk(n_ldr == 4, "R3 short leader rejected", n_ldr, 4);
    chk(bit_count == 2 && end_low == 1, "R2 result unchanged", bit_count, 2);

    // frame E: threshold boundary (R4)
    leader();
    hold(0, 2); hold(1, 4);
    hold(0, 2); hold(1, 3);
    hold(0, 2); hold(1, 30);
    chk(rx_data[1:0] == 2'b01 && bit_count == 2, "R4 threshold edge", rx_data[1:0], 1);
    chk(n_ldr == 5 && end_low == 0, "R8 result after new frame", n_ldr, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule